// File: doc/BRIEF.md
# Cascadable Interrupt Controller with Split Acknowledge

This block is an eight-level priority interrupt controller that can be chained so that one master and up to eight slaves behave as a single 64-level system. A static strap input picks the role of each instance. High selects master and low selects slave. Each slave's interrupt output is wired to one request input of the master, and only the master's interrupt output reaches the processor. All instances share the processor's acknowledge line. The master's three cascade outputs fan out to the cascade inputs of every slave.

An acknowledge is two pulses on `inta`. At the first pulse the master picks its winning input and sets its own in-service bit for it. If a slave is attached to that input, the master also places the input number on the cascade lines. The slave whose programmed identity equals that number then resolves its own winner and marks it in service. At the second pulse exactly one device drives the vector byte `{base[7:3], level}`. That device is the addressed slave for a cascaded input, or the master itself for a plain input. In-service bits are cleared by a non-specific end-of-interrupt pulse, or automatically at the second pulse when that mode is enabled.

Each instance is programmed on its own through a small write port. Priority is fixed, and level 0 is the highest. Request inputs are level-sensitive and are sampled once per clock.

Top module: `casc_intc`

## Requirements
- R1: A master drives `cas_out` with the winning input number from the cycle after the first pulse starts until the cycle after the second pulse ends, but only if that input is flagged as having a slave attached. In every other case `cas_out` is 0, and a slave always outputs 0 on `cas_out`.
- R2: `int_out` is high one cycle after an unmasked request is present on `irq_in`, provided that the request has a lower index than every in-service level, or no level is in service.
- R3: A request whose mask bit is 1 never raises `int_out`. After reset all mask bits are 1.
- R4: For an input without an attached slave, the master drives `data_oe` high during the second pulse, with `data_out = {base[7:3], level}`.
- R5: For an input with an attached slave, the master keeps `data_oe` low and sets its own in-service bit for that input. While that bit is set, further requests on that input and on lower-priority inputs are held off.
- R6: A slave whose identity equals `cas_in` during the first pulse sets the in-service bit of its winning level. It then drives `{base[7:3], level}` with `data_oe` high during the second pulse.
- R7: A slave whose identity does not match keeps `data_oe` low, and its in-service and request state stay as they were. Its pending request still reaches the master afterwards.
- R8: An in-service level blocks `int_out` for requests of equal or lower priority, and it lets a higher-priority request through (nesting).
- R9: With auto end-of-interrupt set, an in-service bit is cleared when the second pulse starts, so no end-of-interrupt command is needed.
- R10: A one-cycle `eoi` pulse clears the highest-priority set in-service bit and no other bit.
- R11: The configuration writes are: `cfg_addr` 0 sets the vector base (bits 7:3), 1 sets the mask, 2 sets the slave-attached mask on a master or the identity (bits 2:0) on a slave, and 3 sets auto end-of-interrupt (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| role_master | input | 1 | Strap: 1 master, 0 slave |
| irq_in | input | 8 | Level-sensitive request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_data | input | 8 | Configuration write data |
| eoi | input | 1 | Non-specific end-of-interrupt pulse |
| inta | input | 1 | Acknowledge pulses, active high |
| cas_in | input | 3 | Cascade number seen by a slave |
| cas_out | output | 3 | Cascade number driven by a master |
| int_out | output | 1 | Interrupt request output |
| data_out | output | 8 | Vector byte |
| data_oe | output | 1 | Vector output enable (0 = bus released) |

## Verification
The assertions assume four things about the inputs. Each acknowledge is exactly two `inta` pulses, and every high and low phase lasts at least one clock. `eoi` arrives only while no acknowledge is in progress. The strap is static. A device keeps its request high until it has been acknowledged. The bench drives all acknowledges through one task that produces fixed-shape pulses. It issues end-of-interrupt only between acknowledges, and it drops each served request line right after its acknowledge. Random request patterns are spread over the master's plain inputs and one slave, and a bench model predicts the winning vector and the cascade number.

// File: rtl/casc_intc.sv
module casc_intc #(
  parameter int LEVELS = 8,
  parameter int IDW = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_master,
  input  logic [LEVELS-1:0] irq_in,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [7:0]        cfg_data,
  input  logic              eoi,
  input  logic              inta,
  input  logic [IDW-1:0]    cas_in,
  output logic [IDW-1:0]    cas_out,
  output logic              int_out,
  output logic [7:0]        data_out,
  output logic              data_oe
);
  localparam int VW = 8 - IDW;

  typedef enum logic [2:0] {ST_IDLE, ST_P1, ST_P1H, ST_GAP, ST_P2, ST_P2H} st_t;

  st_t st;
  logic [LEVELS-1:0] irr, imr, isr, isr_nxt, attach, pend;
  logic [VW-1:0] base_q;
  logic [IDW-1:0] slv_id, lvl_q, cas_q, win_idx, top_idx;
  logic aeoi, valid_q, inv_q, drv_q;
  logic win_any, isr_any, req_ok, match, start_ack;

  always_comb begin
    pend = irr & ~imr;
    win_any = 1'b0;
    win_idx = '0;
    for (int i = LEVELS - 1; i >= 0; i--)
      if (pend[i]) begin
        win_any = 1'b1;
        win_idx = IDW'(i);
      end
    isr_any = 1'b0;
    top_idx = '0;
    for (int i = LEVELS - 1; i >= 0; i--)
      if (isr[i]) begin
        isr_any = 1'b1;
        top_idx = IDW'(i);
      end
  end

  assign req_ok    = win_any && (!isr_any || win_idx < top_idx);
  assign start_ack = (st == ST_IDLE) && inta;
  assign match     = !role_master && (st == ST_P1) && (cas_in == slv_id);

  always_comb begin
    isr_nxt = isr;
    if (eoi && isr_any) isr_nxt[top_idx] = 1'b0;
    if (start_ack && role_master && req_ok) isr_nxt[win_idx] = 1'b1;
    if (match && req_ok) isr_nxt[win_idx] = 1'b1;
    if (st == ST_GAP && inta && aeoi && inv_q && valid_q) isr_nxt[lvl_q] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      irr     <= '0;
      imr     <= '1;
      isr     <= '0;
      attach  <= '0;
      base_q  <= '0;
      slv_id  <= '0;
      aeoi    <= 1'b0;
      lvl_q   <= '0;
      cas_q   <= '0;
      valid_q <= 1'b0;
      inv_q   <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      irr <= irq_in;
      isr <= isr_nxt;
      if (cfg_we)
        case (cfg_addr)
          2'd0: base_q <= cfg_data[7:IDW];
          2'd1: imr <= cfg_data[LEVELS-1:0];
          2'd2: begin
            attach <= cfg_data[LEVELS-1:0];
            slv_id <= cfg_data[IDW-1:0];
          end
          default: aeoi <= cfg_data[0];
        endcase
      case (st)
        ST_IDLE: if (inta) st <= ST_P1;
        ST_P1:   st <= inta ? ST_P1H : ST_GAP;
        ST_P1H:  if (!inta) st <= ST_GAP;
        ST_GAP:  if (inta) st <= ST_P2;
        ST_P2:   st <= inta ? ST_P2H : ST_IDLE;
        default: if (!inta) st <= ST_IDLE;
      endcase
      if (start_ack) begin
        valid_q <= role_master && req_ok;
        lvl_q   <= (role_master && req_ok) ? win_idx : '1;
        inv_q   <= role_master;
        drv_q   <= role_master && !(req_ok && attach[win_idx]);
        cas_q   <= (role_master && req_ok && attach[win_idx]) ? win_idx : '0;
      end
      if (match) begin
        inv_q   <= 1'b1;
        drv_q   <= 1'b1;
        valid_q <= req_ok;
        lvl_q   <= req_ok ? win_idx : '1;
      end
      if ((st == ST_P2 || st == ST_P2H) && !inta) cas_q <= '0;
    end
  end

  assign int_out  = req_ok;
  assign cas_out  = role_master ? cas_q : '0;
  assign data_oe  = (st == ST_P2 || st == ST_P2H) && drv_q;
  assign data_out = data_oe ? {base_q, lvl_q} : 8'h00;

  assert_cas_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_P1H || st == ST_GAP || st == ST_P2 || st == ST_P2H) |-> $stable(cas_out));

  assert_slave_cas_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !role_master |-> cas_out == '0);

  assert_vector_after_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(inta));

  assert_master_inservice_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (role_master && st == ST_P1 && valid_q) |-> isr[lvl_q]);

  assert_eoi_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr != '0 && st == ST_IDLE && !inta) |=> $countones(isr) == $countones($past(isr)) - 1);
endmodule

// File: tb/casc_intc_tb_top.sv
`timescale 1ns/1ps
module casc_intc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, inta = 1'b0;
  logic cfg_we_m = 1'b0, cfg_we_a = 1'b0, cfg_we_b = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic eoi_m = 1'b0, eoi_a = 1'b0, eoi_b = 1'b0;
  logic [7:0] m_ext = '0, a_irq = '0, b_irq = '0, m_irq;
  logic [2:0] cas, a_cas_o, b_cas_o;
  logic m_int, a_int, b_int, m_oe, a_oe, b_oe;
  logic [7:0] m_dat, a_dat, b_dat;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0] c1, c2, c3, c4;
  logic so_m, so_a, so_b;
  logic [7:0] sd_m, sd_a, sd_b;

  always #2 clk = ~clk;

  assign m_irq = {m_ext[7], b_int, m_ext[5:3], a_int, m_ext[1:0]};

  casc_intc dut_i (.clk(clk), .rst_n(rst_n), .role_master(1'b1), .irq_in(m_irq),
    .cfg_we(cfg_we_m), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .eoi(eoi_m),
    .inta(inta), .cas_in(3'd0), .cas_out(cas), .int_out(m_int),
    .data_out(m_dat), .data_oe(m_oe));
  casc_intc slv_a (.clk(clk), .rst_n(rst_n), .role_master(1'b0), .irq_in(a_irq),
    .cfg_we(cfg_we_a), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .eoi(eoi_a),
    .inta(inta), .cas_in(cas), .cas_out(a_cas_o), .int_out(a_int),
    .data_out(a_dat), .data_oe(a_oe));
  casc_intc slv_b (.clk(clk), .rst_n(rst_n), .role_master(1'b0), .irq_in(b_irq),
    .cfg_we(cfg_we_b), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .eoi(eoi_b),
    .inta(inta), .cas_in(cas), .cas_out(b_cas_o), .int_out(b_int),
    .data_out(b_dat), .data_oe(b_oe));

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int dev, input logic [1:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_data = d;
    if (dev == 0) cfg_we_m = 1'b1; else if (dev == 1) cfg_we_a = 1'b1; else cfg_we_b = 1'b1;
    @(negedge clk);
    cfg_we_m = 1'b0; cfg_we_a = 1'b0; cfg_we_b = 1'b0;
  endtask

  task automatic pulse_eoi(input int dev);
    if (dev == 0) eoi_m = 1'b1; else if (dev == 1) eoi_a = 1'b1; else eoi_b = 1'b1;
    @(negedge clk);
    eoi_m = 1'b0; eoi_a = 1'b0; eoi_b = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack();
    inta = 1'b1;
    repeat (3) @(negedge clk);
    c1 = cas;
    inta = 1'b0;
    repeat (2) @(negedge clk);
    c2 = cas;
    inta = 1'b1;
    repeat (2) @(negedge clk);
    c3 = cas;
    so_m = m_oe; so_a = a_oe; so_b = b_oe;
    sd_m = m_dat; sd_a = a_dat; sd_b = b_dat;
    inta = 1'b0;
    repeat (2) @(negedge clk);
    c4 = cas;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int cnt = 0;
    while (!done) begin
      @(posedge clk);
      cnt++;
      if (cnt > 100000 && !done) begin
        fails++; checks++;
        $display("FAIL watchdog actual %0d expected <100000 cycles", cnt);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] apat, ext, cand;
    int w, guard;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cas", cas, 0);
    chk("R2 reset int", {m_int, a_int, b_int}, 0);
    chk("R4 reset oe", {m_oe, a_oe, b_oe}, 0);

    m_ext = 8'h01;
    settle();
    chk("R3 reset mask holds int low", m_int, 0);
    m_ext = 8'h00;

    wr(0, 2'd0, 8'h40); wr(0, 2'd1, 8'h00); wr(0, 2'd2, 8'h44); wr(0, 2'd3, 8'h00);
    wr(1, 2'd0, 8'h80); wr(1, 2'd1, 8'h00); wr(1, 2'd2, 8'h02); wr(1, 2'd3, 8'h00);
    wr(2, 2'd0, 8'hC8); wr(2, 2'd1, 8'h00); wr(2, 2'd2, 8'h06); wr(2, 2'd3, 8'h00);
    settle();

    wr(0, 2'd1, 8'h08);
    m_ext = 8'h08;
    settle();
    chk("R3 masked level 3", m_int, 0);
    wr(0, 2'd1, 8'h00);
    @(negedge clk);
    chk("R2 unmasked level 3 raises int", m_int, 1);
    ack();
    chk("R4 plain input cas idle", {c1, c2, c3, c4}, 0);
    chk("R4 master drives vector", {so_m, sd_m}, {1'b1, 8'h43});
    chk("R11 base register in vector", sd_m[7:3], 5'h08);
    chk("R4 slaves released", {so_a, so_b}, 0);
    m_ext = 8'h00;
    @(negedge clk);
    m_ext = 8'h20;
    settle();
    chk("R8 lower priority blocked", m_int, 0);
    m_ext = 8'h22;
    settle();
    chk("R8 higher priority nests", m_int, 1);
    ack();
    chk("R8 nested vector", sd_m, 8'h41);
    m_ext = 8'h20;
    settle();
    pulse_eoi(0);
    settle();
    chk("R10 eoi clears only top level", m_int, 0);
    pulse_eoi(0);
    settle();
    chk("R10 second eoi releases level 5", m_int, 1);
    ack();
    chk("R4 vector level 5", sd_m, 8'h45);
    m_ext = 8'h00;
    pulse_eoi(0);

    a_irq = 8'h10;
    settle();
    chk("R2 slave request reaches master", m_int, 1);
    ack();
    chk("R1 cas first pulse", c1, 3'd2);
    chk("R1 cas gap", c2, 3'd2);
    chk("R1 cas second pulse", c3, 3'd2);
    chk("R1 cas idle after", c4, 3'd0);
    chk("R5 master releases bus", so_m, 0);
    chk("R6 addressed slave vector", {so_a, sd_a}, {1'b1, 8'h84});
    chk("R7 other slave released", so_b, 0);
    a_irq = 8'h00;
    settle();
    a_irq = 8'h08;
    settle();
    chk("R5 master in-service holds off input 2", m_int, 0);
    a_irq = 8'h00;
    pulse_eoi(1); pulse_eoi(0);

    a_irq = 8'h01; b_irq = 8'h02;
    settle();
    ack();
    chk("R6 slave A served first", {c1, sd_a}, {3'd2, 8'h80});
    chk("R7 slave B silent", so_b, 0);
    a_irq = 8'h00;
    pulse_eoi(1);
    settle();
    chk("R7 slave B request kept", b_int, 1);
    pulse_eoi(0);
    settle();
    chk("R7 master sees slave B", m_int, 1);
    ack();
    chk("R7 slave B vector", {c3, so_b, sd_b}, {3'd6, 1'b1, 8'hC9});
    chk("R7 slave A silent", so_a, 0);
    b_irq = 8'h00;
    pulse_eoi(2); pulse_eoi(0);

    wr(0, 2'd3, 8'h01); wr(1, 2'd3, 8'h01);
    a_irq = 8'h30;
    settle();
    ack();
    chk("R9 aeoi first vector", sd_a, 8'h84);
    a_irq = 8'h20;
    settle();
    chk("R9 next level without eoi", m_int, 1);
    ack();
    chk("R9 aeoi second vector", sd_a, 8'h85);
    a_irq = 8'h00;
    settle();

    for (int it = 0; it < 30; it++) begin
      apat = 8'($urandom);
      ext = 8'($urandom) & 8'hBB;
      if (it == 0) begin apat = 8'h80; ext = 8'h00; end
      if (it == 1) begin apat = 8'h00; ext = 8'h80; end
      if (apat == 0 && ext == 0) ext = 8'h01;
      a_irq = apat; m_ext = ext;
      guard = 0;
      while ((apat != 0 || ext != 0) && guard < 20) begin
        guard++;
        settle();
        chk("R2 random int", m_int, 1);
        cand = ext | ((apat != 0) ? 8'h04 : 8'h00);
        w = lowest(cand);
        ack();
        if (w == 2) begin
          chk("R6 random slave vector", {c1, so_a, sd_a, so_m}, {3'd2, 1'b1, 8'(8'h80 + lowest(apat)), 1'b0});
          apat[lowest(apat)] = 1'b0;
        end else begin
          chk("R4 random master vector", {c1, so_m, sd_m, so_a}, {3'd0, 1'b1, 8'(8'h40 + w), 1'b0});
          ext[w] = 1'b0;
        end
        a_irq = apat; m_ext = ext;
      end
    end
    settle();
    chk("R2 idle after drain", m_int, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule